// File: doc/BRIEF.md
# DDR Read Burst Output Sequencer

This block is the device-side read path of a double-data-rate SDRAM model. It watches the command pins once per CK cycle, recognises a READ, and latches the bank, the starting column and the auto-precharge flag. It then fetches the burst from a synchronous storage port one element pair per CK cycle. After the selected CAS latency it places the elements on DQ, one per CK half cycle, and drives the strobe alongside them.

The block runs on an internal clock at twice the CK rate, so one internal cycle is half a CK cycle. Output `ck_hi` is high during the first half of each CK cycle, and commands are sampled only then. A READ may arrive on any CK cycle while an earlier burst is still running. The earlier burst then yields exactly two elements per CK cycle of spacing, and the new burst's first element follows the last delivered one with no gap. The strobe is driven LOW for one CK cycle ahead of a fresh stream (preamble). It is LOW with the final element (postamble), and both bus enables drop once the stream ends.

Top module: `ddr_rd_seq`

## Requirements
- R1: A READ is sampled only in an internal cycle with `ck_hi`=1 and only when cke=1, cs_n=0, ras_n=1, cas_n=0 and we_n=1. Any other pin combination, a deselected chip or cke=0 produces no fetch and no bus activity.
- R2: For each element pair of a burst, `mem_rd_en` is high for one internal cycle, the cycle after the pair is scheduled (the command cycle for the first pair, then every second internal cycle). `mem_addr` = {bank, column} with column bit 0 forced to 0, so address bit A0 of the command is ignored. The storage returns the pair one internal cycle later: the even element in the low half of `mem_rdata` and the odd element in the high half.
- R3: The first element appears on `dq_out` (with `dq_oe`=1) 4, 5 or 6 internal cycles after the command cycle, for `cl_sel` = 0 (CL 2), 1 (CL 2.5) and 2 (CL 3). `cl_sel`=3 behaves as CL 3.
- R4: Elements follow in sequence, one per internal cycle. The even element of each pair comes first. The pair column advances by 2 and wraps within the block aligned to the burst length. `bl_sel` = 0, 1 and 2 select 2, 4 and 8 elements, and 3 selects 8.
- R5: `dqs_oe` is high whenever `dq_oe` is high. `dqs_out` is 1 with even elements and 0 with odd ones. In the two internal cycles before a stream that does not continue an earlier one, `dqs_oe`=1, `dqs_out`=0 and `dq_oe`=0.
- R6: The last element of a stream carries `dqs_out`=0. In the internal cycle after it, `dq_oe` and `dqs_oe` are both 0 unless a preamble is due.
- R7: A READ issued x CK cycles after an earlier one, with 2x below the burst length, cuts the earlier burst after 2x elements. If 2x equals the burst length, the bursts join. In both cases the new burst's first element comes in the internal cycle right after the earlier burst's last delivered element.
- R8: When A8 was 1 on the READ, `pre_req` pulses for one internal cycle, together with the last element delivered from that burst (completed or cut short). `pre_bank` then shows the burst's bank.
- R9: While rst_n is low at a clock edge, all bus enables, `mem_rd_en` and `pre_req` are 0 in the following cycle, and the CK phase restarts with `ck_hi`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock, twice the CK rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cl_sel | input | 2 | CAS latency select (static) |
| bl_sel | input | 2 | Burst length select (static) |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 9 | Column address in bits 7:0, auto-precharge flag in bit 8 |
| ck_hi | output | 1 | High in the first half of each CK cycle |
| mem_rd_en | output | 1 | Storage pair fetch strobe |
| mem_addr | output | 10 | Fetch address {bank, even column} |
| mem_rdata | input | 64 | Fetched pair: odd element high, even element low |
| dq_out | output | 32 | Data element driven on DQ |
| dq_oe | output | 1 | DQ output enable |
| dqs_out | output | 1 | Strobe level |
| dqs_oe | output | 1 | Strobe output enable |
| pre_req | output | 1 | Auto-precharge request pulse |
| pre_bank | output | 2 | Bank for the precharge request |

## Verification
A command sampled in internal cycle T leads to its first fetch in T+1 and the returned pair in T+2. Its first element follows in T+4, T+5 or T+6, depending on latency. Each further element comes one cycle later, and the preamble covers the two cycles before the first element. The bench builds, from the issued commands alone, an expected value for every internal cycle of a fixed window: fetch strobe and address, both enables, strobe level, data and precharge pulse. It drives the pins and samples the outputs at the falling clock edge, so each comparison lands on exactly the internal cycle in which the result is due.

// File: rtl/ddr_rd_pkg.sv
// Shared constants, the per-pair slot record and the latency and burst
// length decoders used by the read sequencer. Assumes two bank bits and
// an eight-bit column address.
package ddr_rd_pkg;
    localparam int unsigned BA_W    = 2;
    localparam int unsigned COL_W   = 8;
    localparam int unsigned CLH_MAX = 6;            // largest latency in half cycles
    localparam int unsigned PIPE_D  = CLH_MAX + 1;  // deepest tap of the delay chain
    localparam int unsigned LEFT_W  = 3;

    // One scheduled element pair travelling down the output delay chain
    typedef struct packed {
        logic            v;
        logic            ap;
        logic            tag;
        logic [BA_W-1:0] bank;
    } slot_t;

    // CAS latency in internal (half CK) cycles
    function automatic logic [2:0] cl_half(input logic [1:0] sel);
        case (sel)
            2'd0:    return 3'd4;
            2'd1:    return 3'd5;
            default: return 3'd6;
        endcase
    endfunction

    // Burst length in elements
    function automatic logic [3:0] bl_len(input logic [1:0] sel);
        case (sel)
            2'd0:    return 4'd2;
            2'd1:    return 4'd4;
            default: return 4'd8;
        endcase
    endfunction
endpackage

// File: rtl/ddr_rd_cmd_dec.sv
// Command decoder: recognises a READ on the command pins in the first
// half of a CK cycle and splits out bank, even-aligned column and the
// auto-precharge flag. Assumes the pins are stable over that half cycle.
module ddr_rd_cmd_dec
    import ddr_rd_pkg::*;
#(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned AP_BIT = 8
) (
    input  logic              ck_hi,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_hit,
    output logic [BA_W-1:0]   rd_bank,
    output logic [COL_W-1:0]  rd_col,
    output logic              rd_ap
);
    // Decode the READ encoding and split the address fields
    always_comb begin
        rd_hit  = ck_hi & cke & ~cs_n & ras_n & ~cas_n & we_n;
        rd_bank = ba;
        rd_col  = addr[COL_W-1:0] & ~COL_W'(1);
        rd_ap   = addr[AP_BIT];
    end
endmodule

// File: rtl/ddr_rd_burst_gen.sv
// Burst generator: schedules one element pair per CK cycle, starting in
// the command cycle. A new READ replaces any burst in progress. Issues the
// storage fetch one internal cycle after scheduling. Assumes the storage
// answers with a fixed one-cycle latency.
module ddr_rd_burst_gen
    import ddr_rd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ck_hi,
    input  logic [1:0]            bl_sel,
    input  logic                  rd_hit,
    input  logic [BA_W-1:0]       rd_bank,
    input  logic [COL_W-1:0]      rd_col,
    input  logic                  rd_ap,
    output slot_t                 slot_q,
    output logic                  mem_rd_en,
    output logic [BA_W+COL_W-1:0] mem_addr
);
    logic              act;
    logic [BA_W-1:0]   cur_bank;
    logic [COL_W-1:0]  cur_col;
    logic              cur_ap;
    logic              cur_tag;
    logic [LEFT_W-1:0] left;

    logic              s_v;
    logic [BA_W-1:0]   s_bank;
    logic [COL_W-1:0]  s_col;
    logic              s_ap;
    logic              s_tag;
    logic [LEFT_W-1:0] left_n;
    logic [COL_W-1:0]  wrap_mask;
    logic [COL_W-1:0]  nxt_col;
    logic [3:0]        bl;
    logic [BA_W+COL_W-1:0] addr_q;

    // Pick this cycle's pair: a fresh READ wins over the running burst
    always_comb begin
        bl        = bl_len(bl_sel);
        wrap_mask = COL_W'(bl - 4'd1);
        s_v       = 1'b0;
        s_bank    = cur_bank;
        s_col     = cur_col;
        s_ap      = cur_ap;
        s_tag     = cur_tag;
        left_n    = left;
        if (rd_hit) begin
            s_v    = 1'b1;
            s_bank = rd_bank;
            s_col  = rd_col;
            s_ap   = rd_ap;
            s_tag  = ~cur_tag;
            left_n = LEFT_W'(bl >> 1) - LEFT_W'(1);
        end else if (ck_hi && act) begin
            s_v    = 1'b1;
            left_n = left - LEFT_W'(1);
        end
        nxt_col = (s_col & ~wrap_mask) | ((s_col + COL_W'(2)) & wrap_mask);
    end

    // Advance the burst state and register the fetch request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act      <= 1'b0;
            cur_bank <= '0;
            cur_col  <= '0;
            cur_ap   <= 1'b0;
            cur_tag  <= 1'b0;
            left     <= '0;
            slot_q   <= '0;
            addr_q   <= '0;
        end else begin
            if (s_v) begin
                act      <= (left_n != '0);
                cur_bank <= s_bank;
                cur_col  <= nxt_col;
                cur_ap   <= s_ap;
                cur_tag  <= s_tag;
                left     <= left_n;
            end
            slot_q <= '{v: s_v, ap: s_ap, tag: s_tag, bank: s_bank};
            addr_q <= {s_bank, s_col};
        end
    end

    assign mem_rd_en = slot_q.v;
    assign mem_addr  = addr_q;

    AST_FETCH_SECOND_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !ck_hi);  // R2
    AST_FETCH_EVEN_COL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !mem_addr[0]);  // R2
    AST_FETCH_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);  // R2
endmodule

// File: rtl/ddr_rd_out_pipe.sv
// Output pipeline: delays each scheduled pair by the CAS latency, counted
// in half CK cycles. Drives the even element then the odd one, generates
// strobe preamble and postamble, and raises the auto-precharge request on
// a burst's last delivered element. Assumes pairs arrive no closer than
// two internal cycles apart.
module ddr_rd_out_pipe
    import ddr_rd_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cl_sel,
    input  slot_t               slot_in,
    input  logic [2*DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0]   dq_out,
    output logic                dq_oe,
    output logic                dqs_out,
    output logic                dqs_oe,
    output logic                pre_req,
    output logic [BA_W-1:0]     pre_bank
);
    localparam int unsigned PAIR_W = 2 * DATA_W;

    slot_t             meta   [1:PIPE_D];
    slot_t             meta_q [2:PIPE_D];
    logic [PAIR_W-1:0] pair   [2:PIPE_D];
    logic [PAIR_W-1:0] pair_q [3:PIPE_D];
    int unsigned       clh;
    logic              ev;
    logic              od;
    logic              preamble;

    // Assemble the tap views: stage k holds the pair scheduled k cycles ago
    always_comb begin
        meta[1] = slot_in;
        for (int k = 2; k <= PIPE_D; k++) meta[k] = meta_q[k];
        pair[2] = mem_rdata;
        for (int k = 3; k <= PIPE_D; k++) pair[k] = pair_q[k];
    end

    // Shift metadata and fetched data one stage per internal cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 2; k <= PIPE_D; k++) meta_q[k] <= '0;
            for (int k = 3; k <= PIPE_D; k++) pair_q[k] <= '0;
        end else begin
            for (int k = 2; k <= PIPE_D; k++) meta_q[k] <= meta[k-1];
            for (int k = 3; k <= PIPE_D; k++) pair_q[k] <= pair[k-1];
        end
    end

    // Select the element due now, the strobe and the precharge pulse
    always_comb begin
        clh      = int'(cl_half(cl_sel));
        ev       = meta[clh].v;
        od       = meta[clh+1].v;
        dq_oe    = ev | od;
        dq_out   = ev ? pair[clh][DATA_W-1:0] : pair[clh+1][PAIR_W-1:DATA_W];
        dqs_out  = ev;
        preamble = ~dq_oe & (meta[clh-2].v | meta[clh-1].v);
        dqs_oe   = dq_oe | preamble;
        pre_req  = od & meta[clh+1].ap &
                   ~(meta[clh-1].v & (meta[clh-1].tag == meta[clh+1].tag));
        pre_bank = meta[clh+1].bank;
    end

    AST_ONE_ELEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev, od}));  // R4
    AST_STROBE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe && $past(dq_oe) |-> dqs_out != $past(dqs_out));  // R5
    AST_START_AFTER_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> dqs_out && $past(dqs_oe) && !$past(dqs_out));  // R5
    AST_PREAMBLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_oe && !dq_oe |=> dqs_oe);  // R5
    AST_LAST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_oe) |-> !$past(dqs_out));  // R6
    AST_PRECHARGE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        pre_req |-> dq_oe && !dqs_out);  // R8
endmodule

// File: rtl/ddr_rd_seq.sv
// Top of the read burst sequencer: tracks the CK phase on the double-rate
// internal clock and ties decoder, burst generator and output pipeline
// together. Assumes cl_sel and bl_sel change only while the bus is idle.
module ddr_rd_seq
    import ddr_rd_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned AP_BIT = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            cl_sel,
    input  logic [1:0]            bl_sel,
    input  logic                  cke,
    input  logic                  cs_n,
    input  logic                  ras_n,
    input  logic                  cas_n,
    input  logic                  we_n,
    input  logic [BA_W-1:0]       ba,
    input  logic [ADDR_W-1:0]     addr,
    output logic                  ck_hi,
    output logic                  mem_rd_en,
    output logic [BA_W+COL_W-1:0] mem_addr,
    input  logic [2*DATA_W-1:0]   mem_rdata,
    output logic [DATA_W-1:0]     dq_out,
    output logic                  dq_oe,
    output logic                  dqs_out,
    output logic                  dqs_oe,
    output logic                  pre_req,
    output logic [BA_W-1:0]       pre_bank
);
    logic             ph;
    logic             rd_hit;
    logic [BA_W-1:0]  rd_bank;
    logic [COL_W-1:0] rd_col;
    logic             rd_ap;
    slot_t            slot_q;

    // CK phase: 0 in the half cycle following a rising CK edge
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= 1'b0;
        else        ph <= ~ph;
    end

    assign ck_hi = ~ph;

    ddr_rd_cmd_dec #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) i_dec (
        .ck_hi  (ck_hi),
        .cke    (cke),
        .cs_n   (cs_n),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .we_n   (we_n),
        .ba     (ba),
        .addr   (addr),
        .rd_hit (rd_hit),
        .rd_bank(rd_bank),
        .rd_col (rd_col),
        .rd_ap  (rd_ap)
    );

    ddr_rd_burst_gen i_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .ck_hi    (ck_hi),
        .bl_sel   (bl_sel),
        .rd_hit   (rd_hit),
        .rd_bank  (rd_bank),
        .rd_col   (rd_col),
        .rd_ap    (rd_ap),
        .slot_q   (slot_q),
        .mem_rd_en(mem_rd_en),
        .mem_addr (mem_addr)
    );

    ddr_rd_out_pipe #(.DATA_W(DATA_W)) i_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .cl_sel   (cl_sel),
        .slot_in  (slot_q),
        .mem_rdata(mem_rdata),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe),
        .dqs_out  (dqs_out),
        .dqs_oe   (dqs_oe),
        .pre_req  (pre_req),
        .pre_bank (pre_bank)
    );

    AST_NO_READ_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || !cke) && !mem_rd_en |=> !mem_rd_en || $past(ph) == 1'b0);  // R1
endmodule

// File: tb/test_ddr_rd_seq.sv
// Directed bench for the read sequencer: each scenario task lists its
// commands, derives the expected bus for every internal cycle of a window
// and compares at the falling clock edge.
module test_ddr_rd_seq;
    localparam int WIN = 48;
    localparam int ARR = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cl_sel = 2'd0;
    logic [1:0]  bl_sel = 2'd1;
    logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = 2'd0;
    logic [8:0]  addr = 9'd0;
    logic        ck_hi;
    logic        mem_rd_en;
    logic [9:0]  mem_addr;
    logic [63:0] mem_rdata = '0;
    logic [31:0] dq_out;
    logic        dq_oe, dqs_out, dqs_oe, pre_req;
    logic [1:0]  pre_bank;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // scenario command list
    int         n_rd;
    int         rt [4];
    int         rk [4];
    logic [1:0] rb [4];
    logic [7:0] rc [4];
    logic       ra [4];

    // expected bus per internal cycle
    bit          x_v  [ARR];
    logic [31:0] x_d  [ARR];
    bit          x_s  [ARR];
    bit          x_pre[ARR];
    bit          x_pr [ARR];
    logic [1:0]  x_pb [ARR];
    bit          x_f  [ARR];
    logic [9:0]  x_fa [ARR];

    always #2.5 clk = ~clk;  // 200 MHz

    ddr_rd_seq i_ddr_rd_seq (
        .clk(clk), .rst_n(rst_n), .cl_sel(cl_sel), .bl_sel(bl_sel),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .ck_hi(ck_hi), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .dq_out(dq_out),
        .dq_oe(dq_oe), .dqs_out(dqs_out), .dqs_oe(dqs_oe),
        .pre_req(pre_req), .pre_bank(pre_bank)
    );

    function automatic logic [31:0] elem(input logic [1:0] b, input logic [7:0] c);
        return {6'b101101, b, 8'h3C, ~c, c};
    endfunction

    // storage model: one-cycle read latency, even element in the low half
    always @(posedge clk)
        if (mem_rd_en)
            mem_rdata <= {elem(mem_addr[9:8], mem_addr[7:0] | 8'h01),
                          elem(mem_addr[9:8], mem_addr[7:0])};

    task automatic chk(input string req, input string what, input int h,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s cycle=%0d actual=%h expected=%h", req, what, h, act, exp);
        end
    endtask

    task automatic add_rd(input int t, input int kind, input logic [1:0] b,
                          input logic [7:0] c, input logic ap);
        rt[n_rd] = t; rk[n_rd] = kind; rb[n_rd] = b; rc[n_rd] = c; ra[n_rd] = ap;
        n_rd++;
    endtask

    task automatic idle_pins();
        cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        ba = 2'd0; addr = 9'd0;
    endtask

    // Build expectations from the command list, then drive and compare
    task automatic run(input string req);
        int clh;
        int bl;
        logic [7:0] mask;
        clh  = (cl_sel == 2'd0) ? 4 : (cl_sel == 2'd1) ? 5 : 6;
        bl   = (bl_sel == 2'd0) ? 2 : (bl_sel == 2'd1) ? 4 : 8;
        mask = 8'(bl - 1);
        for (int h = 0; h < ARR; h++) begin
            x_v[h] = 0; x_d[h] = '0; x_s[h] = 0; x_pre[h] = 0;
            x_pr[h] = 0; x_pb[h] = '0; x_f[h] = 0; x_fa[h] = '0;
        end
        for (int i = 0; i < n_rd; i++) begin
            if (rk[i] == 0) begin
                int cnt;
                logic [7:0] c0;
                cnt = bl;
                for (int j = i + 1; j < n_rd; j++) begin
                    if (rk[j] == 0) begin
                        if (rt[j] - rt[i] < cnt) cnt = rt[j] - rt[i];
                        break;
                    end
                end
                c0 = rc[i] & 8'hFE;
                for (int e = 0; e < cnt; e++) begin
                    logic [7:0] pc;
                    int h;
                    pc = (c0 & ~mask) | ((c0 + 8'(2 * (e / 2))) & mask);
                    h = rt[i] + clh + e;
                    x_v[h] = 1;
                    x_d[h] = elem(rb[i], pc | 8'(e % 2));
                    x_s[h] = (e % 2 == 0);
                    if (ra[i] && e == cnt - 1) begin x_pr[h] = 1; x_pb[h] = rb[i]; end
                    if (e % 2 == 0) begin x_f[rt[i] + e + 1] = 1; x_fa[rt[i] + e + 1] = {rb[i], pc}; end
                end
            end
        end
        for (int h = 0; h < ARR - 2; h++)
            x_pre[h] = !x_v[h] && (x_v[h+1] || x_v[h+2]);

        @(negedge clk);
        while (!ck_hi) @(negedge clk);
        for (int h = 0; h < WIN; h++) begin
            idle_pins();
            for (int i = 0; i < n_rd; i++) begin
                if (rt[i] == h) begin
                    cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b1;
                    ba = rb[i]; addr = {ra[i], rc[i]};
                    if (rk[i] == 1) cs_n = 1'b1;
                    if (rk[i] == 2) cke = 1'b0;
                    if (rk[i] == 3) we_n = 1'b0;
                end
            end
            chk("R2", "mem_rd_en", h, 32'(mem_rd_en), 32'(x_f[h]));
            if (x_f[h]) chk("R2", "mem_addr", h, 32'(mem_addr), 32'(x_fa[h]));
            chk(req, "dq_oe", h, 32'(dq_oe), 32'(x_v[h]));
            if (x_v[h]) chk(req, "dq_out", h, dq_out, x_d[h]);
            chk(req, "dqs_oe", h, 32'(dqs_oe), 32'(x_v[h] || x_pre[h]));
            if (x_v[h] || x_pre[h]) chk(req, "dqs_out", h, 32'(dqs_out), 32'(x_s[h]));
            chk(req, "pre_req", h, 32'(pre_req), 32'(x_pr[h]));
            if (x_pr[h]) chk(req, "pre_bank", h, 32'(pre_bank), 32'(x_pb[h]));
            @(negedge clk);
        end
        idle_pins();
        n_rd = 0;
    endtask

    // R9: outputs idle during reset even with a READ on the pins
    task automatic t_reset();
        rst_n = 1'b0;
        cs_n = 1'b0; cas_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9", "dq_oe", 0, 32'(dq_oe), 0);
        chk("R9", "dqs_oe", 0, 32'(dqs_oe), 0);
        chk("R9", "mem_rd_en", 0, 32'(mem_rd_en), 0);
        chk("R9", "pre_req", 0, 32'(pre_req), 0);
        chk("R9", "ck_hi", 0, 32'(ck_hi), 1);
        idle_pins();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // R3: CL2 and CL2.5 first-element position, BL4
    task automatic t_latency();
        cl_sel = 2'd0; bl_sel = 2'd1;
        add_rd(2, 0, 2'd1, 8'h10, 1'b0);
        run("R3");
        cl_sel = 2'd1;
        add_rd(4, 0, 2'd0, 8'h40, 1'b0);
        run("R3");
    endtask

    // R4: BL8 at CL3 wraps inside the aligned block of eight
    task automatic t_wrap();
        cl_sel = 2'd2; bl_sel = 2'd2;
        add_rd(0, 0, 2'd2, 8'h0D, 1'b0);
        run("R4");
    endtask

    // R2: odd start column is aligned down, BL2
    task automatic t_odd_col();
        cl_sel = 2'd0; bl_sel = 2'd0;
        add_rd(2, 0, 2'd3, 8'h31, 1'b0);
        run("R2");
    endtask

    // R1: deselect, cke low and write encoding are ignored; a real READ follows
    task automatic t_ignored();
        cl_sel = 2'd0; bl_sel = 2'd1;
        add_rd(0, 1, 2'd1, 8'h20, 1'b1);
        add_rd(2, 2, 2'd2, 8'h24, 1'b1);
        add_rd(4, 3, 2'd3, 8'h28, 1'b1);
        add_rd(14, 0, 2'd0, 8'h2C, 1'b0);
        run("R1");
    endtask

    // R7: concatenation of BL4 bursts at CL3 selected with code 3
    task automatic t_concat();
        cl_sel = 2'd3; bl_sel = 2'd1;
        add_rd(0, 0, 2'd0, 8'h04, 1'b0);
        add_rd(4, 0, 2'd1, 8'h80, 1'b0);
        add_rd(8, 0, 2'd2, 8'hF6, 1'b0);
        run("R7");
    endtask

    // R7: BL8 burst cut after two pairs, then after one pair
    task automatic t_trunc();
        cl_sel = 2'd1; bl_sel = 2'd2;
        add_rd(0, 0, 2'd3, 8'h18, 1'b0);
        add_rd(4, 0, 2'd0, 8'h50, 1'b0);
        add_rd(6, 0, 2'd1, 8'h60, 1'b0);
        run("R7");
    endtask

    // R5: one idle CK cycle between bursts brings a fresh preamble
    task automatic t_gap();
        cl_sel = 2'd0; bl_sel = 2'd0;
        add_rd(0, 0, 2'd1, 8'h02, 1'b0);
        add_rd(4, 0, 2'd2, 8'h06, 1'b0);
        run("R5");
    endtask

    // R6: a lone burst ends with a low strobe and then releases the bus
    task automatic t_end();
        cl_sel = 2'd2; bl_sel = 2'd0;
        add_rd(2, 0, 2'd0, 8'hA0, 1'b0);
        run("R6");
    endtask

    // R8: auto precharge on a truncated burst and on a completed one
    task automatic t_ap();
        cl_sel = 2'd0; bl_sel = 2'd1;
        add_rd(0, 0, 2'd2, 8'h30, 1'b1);
        add_rd(2, 0, 2'd3, 8'h44, 1'b1);
        add_rd(12, 0, 2'd1, 8'h08, 1'b0);
        run("R8");
    endtask

    initial begin
        n_rd = 0;
        t_reset();
        t_latency();
        t_wrap();
        t_odd_col();
        t_ignored();
        t_concat();
        t_trunc();
        t_gap();
        t_end();
        t_ap();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule